// File: doc/BRIEF.md
# Serial Bitstream Loader

This block loads a configuration image into an attached programmable device over a one-bit serial path. When `start_i` is pulsed, it pulls the device's program line low. It waits for the device to signal that it has cleared itself, releases the program line, and waits for the device to report that it is ready. It then takes image bytes from an upstream valid/ready source and shifts each byte out most-significant bit first on a data line. The data line is qualified by a configuration clock that the block generates from the system clock. After the last byte the data line is held high, and the block keeps pulsing the clock until the device reports completion.

The device's two status lines, the init line and the done line, pass through two-flop synchronisers before the controller uses them. Before each byte the block checks the status lines. If the init line is low while the done line is still low, the device has reported a checksum error and the load stops. Each of the three waits has its own timeout of `WAIT_CYC` system cycles. The default of 2,000,000 cycles is 10 ms at 200 MHz. The outcome is left on a 2-bit result code that is held until the next start.

The controller has six states, and each transition is named after the condition that causes it:
- IDLE. `start` moves it to PROG.
- PROG. `init_low` moves it to WAKE, and `expire` moves it to IDLE.
- WAKE. `init_high` moves it to FETCH, and `expire` moves it to IDLE.
- FETCH. `empty` moves it to FLUSH, `crc` moves it to IDLE, and `accept` moves it to SHIFT.
- SHIFT. `byte_end` moves it back to FETCH.
- FLUSH. `done_seen` moves it to IDLE, and `expire` moves it to IDLE.

Top module: `cfg_serial_master`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o`=0, `cfg_prog_n_o`=1, `cfg_clk_o`=0 and `s_ready_o`=0. `result_o` is 2'b00 (none) after reset.
- R2: A start drives `cfg_prog_n_o` low until the synchronised init line reads low. If that does not happen within `WAIT_CYC` cycles, the program line is released and the load ends with `result_o`=2'b10 (timeout).
- R3: Once init has read low, `cfg_prog_n_o` returns high and no data is sent until init reads high again. If init does not read high within `WAIT_CYC` cycles, the load ends with `result_o`=2'b10.
- R4: Each byte is sent as 8 bits, most-significant bit first. A bit is placed on `cfg_dat_o` while `cfg_clk_o` is low and is stable at the rising edge of `cfg_clk_o`.
- R5: Every high phase and every low phase of `cfg_clk_o` lasts at least `HALF_CYC` system cycles.
- R6: `s_ready_o` is high only between bytes of an active load, with the program line released and the clock low. Exactly `byte_total_i` bytes (the value captured at start) are taken, and a count of zero sends no data.
- R7: Before each byte, if init reads low while done reads low, no further byte is taken and the load ends with `result_o`=2'b11 (checksum error).
- R8: After the last byte, `cfg_dat_o` stays high and clock pulses continue until done reads high. The load then ends with the clock low and `result_o`=2'b01 (ok). If done does not read high within `WAIT_CYC` cycles, the load ends with 2'b10.
- R9: `busy_o` is high from the start until the load ends. Every ending leaves a non-zero `result_o`, which holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (sampled in IDLE) |
| byte_total_i | input | CNT_W | Number of image bytes to send |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_ready_o | output | 1 | Block accepts an image byte |
| tgt_init_i | input | 1 | Device init status line (asynchronous) |
| tgt_done_i | input | 1 | Device done status line (asynchronous) |
| cfg_prog_n_o | output | 1 | Active-low program line to the device |
| cfg_clk_o | output | 1 | Configuration clock to the device |
| cfg_dat_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| result_o | output | 2 | 00 none, 01 ok, 10 timeout, 11 checksum error |

## Verification
The checksum-error exit is the hardest case to reach. It needs the init line to fall between two bytes while done is still low, after the reset handshake has already driven init low and then high again. The stimulus gets there with a bench device model. The model completes the handshake normally and lets the first byte go out. It counts rising edges of the configuration clock, pulls init low at the eighth edge, and only then offers the next byte. This lets the bench show that the offered byte is never clocked out. The second-phase timeout is reached in a similar way: the model answers the program pulse but never releases init.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAKE,
        ST_FETCH,
        ST_SHIFT,
        ST_FLUSH
    } cfgm_state_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_OK   = 2'b01,
        RES_TMO  = 2'b10,
        RES_CRC  = 2'b11
    } cfgm_res_e;

endpackage

// File: rtl/cfgm_sync.sv
module cfgm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfgm_tick.sv
module cfgm_tick #(
    parameter int HALF_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = $clog2(HALF_CYC + 1);
    localparam logic [W-1:0] LAST = W'(HALF_CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!run_i)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cfgm_wait.sv
module cfgm_wait #(
    parameter int LIMIT = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    assign expired_o = (cnt_q == TW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr_i)      cnt_q <= '0;
        else if (!expired_o) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfgm_pkg::*;
#(
    parameter int HALF_CYC = 10,
    parameter int WAIT_CYC = 2000000,
    parameter int CNT_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] byte_total_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    input  logic             tgt_init_i,
    input  logic             tgt_done_i,
    output logic             cfg_prog_n_o,
    output logic             cfg_clk_o,
    output logic             cfg_dat_o,
    output logic             busy_o,
    output logic [1:0]       result_o
);
    localparam logic [2:0] LAST_BIT = 3'd7;

    cfgm_state_e      state_q, state_d;
    logic             init_s, done_s, tick, expired, tmr_clr, crc_hit;
    logic             clk_q, dat_q;
    logic [7:0]       sh_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] left_q;
    cfgm_res_e        res_q;

    cfgm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_init_sync (
        .clk(clk), .rst_n(rst_n), .d_i(tgt_init_i), .q_o(init_s));
    cfgm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_done_sync (
        .clk(clk), .rst_n(rst_n), .d_i(tgt_done_i), .q_o(done_s));
    cfgm_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .run_i((state_q == ST_SHIFT) || (state_q == ST_FLUSH)), .tick_o(tick));
    cfgm_wait #(.LIMIT(WAIT_CYC)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .expired_o(expired));

    assign crc_hit = !init_s && !done_s;
    assign tmr_clr = (state_d != state_q) || (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_PROG;
            ST_PROG:  if (!init_s) state_d = ST_WAKE;
                      else if (expired) state_d = ST_IDLE;
            ST_WAKE:  if (init_s) state_d = ST_FETCH;
                      else if (expired) state_d = ST_IDLE;
            ST_FETCH: if (left_q == '0) state_d = ST_FLUSH;
                      else if (crc_hit) state_d = ST_IDLE;
                      else if (s_valid_i) state_d = ST_SHIFT;
            ST_SHIFT: if (tick && clk_q && (bit_q == LAST_BIT)) state_d = ST_FETCH;
            ST_FLUSH: if (done_s && !clk_q) state_d = ST_IDLE;
                      else if (expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pin, shifter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            dat_q  <= 1'b1;
            sh_q   <= '0;
            bit_q  <= '0;
            left_q <= '0;
            res_q  <= RES_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    res_q  <= RES_NONE;
                    left_q <= byte_total_i;
                end
                ST_PROG: if (init_s && expired) res_q <= RES_TMO;
                ST_WAKE: if (!init_s && expired) res_q <= RES_TMO;
                ST_FETCH: begin
                    if (left_q == '0) dat_q <= 1'b1;
                    else if (crc_hit) res_q <= RES_CRC;
                    else if (s_valid_i) begin
                        sh_q  <= s_data_i;
                        dat_q <= s_data_i[7];
                        bit_q <= '0;
                        clk_q <= 1'b0;
                    end
                end
                ST_SHIFT: if (tick) begin
                    if (!clk_q) clk_q <= 1'b1;
                    else begin
                        clk_q <= 1'b0;
                        if (bit_q == LAST_BIT) left_q <= left_q - CNT_W'(1);
                        else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                            dat_q <= sh_q[6];
                        end
                    end
                end
                ST_FLUSH: begin
                    if (done_s && !clk_q) res_q <= RES_OK;
                    else if (expired) begin
                        res_q <= RES_TMO;
                        clk_q <= 1'b0;
                    end else if (tick) clk_q <= ~clk_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        cfg_prog_n_o = (state_q != ST_PROG);
        s_ready_o    = (state_q == ST_FETCH) && (left_q != '0) && !crc_hit;
        cfg_clk_o    = clk_q;
        cfg_dat_o    = dat_q;
        result_o     = res_q;
    end

    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cfg_clk_o && cfg_prog_n_o && !s_ready_o)); // R1
    AST_PROG_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_prog_n_o |-> (busy_o && !cfg_clk_o)); // R2
    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> $stable(cfg_dat_o)); // R4
    AST_READY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (cfg_prog_n_o && !cfg_clk_o && busy_o)); // R6
    AST_FLUSH_DAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> cfg_dat_o); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o)); // R9
    AST_END_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (result_o != RES_NONE)); // R9
endmodule

// File: tb/sim_cfg_serial_master.sv
module sim_cfg_serial_master;
    localparam int HALF = 2;
    localparam int WAIT = 300;
    localparam int CW   = 8;
    localparam real TCK = 5.0;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] total = '0;
    logic [7:0]    sdata = '0;
    logic          svalid = 1'b0, init_pin = 1'b1, done_pin = 1'b0;
    logic          s_ready_o, cfg_prog_n_o, cfg_clk_o, cfg_dat_o, busy_o;
    logic [1:0]    result_o;

    int n_run = 0, n_fail = 0, cap_n = 0, rdy_bad = 0;
    bit capb [0:1023];
    real t_last = 0.0, min_lo = 1.0e9, min_hi = 1.0e9;

    always #2.5 clk = ~clk;

    cfg_serial_master #(.HALF_CYC(HALF), .WAIT_CYC(WAIT), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_total_i(total),
        .s_data_i(sdata), .s_valid_i(svalid), .s_ready_o(s_ready_o),
        .tgt_init_i(init_pin), .tgt_done_i(done_pin),
        .cfg_prog_n_o(cfg_prog_n_o), .cfg_clk_o(cfg_clk_o), .cfg_dat_o(cfg_dat_o),
        .busy_o(busy_o), .result_o(result_o));

    always @(posedge cfg_clk_o) begin
        if (cap_n < 1024) capb[cap_n] = cfg_dat_o;
        cap_n++;
    end

    always @(cfg_clk_o) begin
        if (cfg_clk_o) begin if ($realtime - t_last < min_lo) min_lo = $realtime - t_last; end
        else           begin if ($realtime - t_last < min_hi) min_hi = $realtime - t_last; end
        t_last = $realtime;
    end

    always @(negedge clk)
        if (s_ready_o && (!busy_o || !cfg_prog_n_o || cfg_clk_o)) rdy_bad++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic kick(input int n);
        cap_n = 0; min_lo = 1.0e9; min_hi = 1.0e9;
        @(negedge clk); total = CW'(n); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic handshake();
        wait (!cfg_prog_n_o);
        repeat (6) @(negedge clk);
        init_pin = 1'b0;
        wait (cfg_prog_n_o);
        repeat (6) @(negedge clk);
        init_pin = 1'b1;
    endtask

    task automatic feed(input logic [7:0] b);
        @(negedge clk); sdata = b; svalid = 1'b1;
        while (!s_ready_o) @(negedge clk);
        @(negedge clk); svalid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy_o && cfg_prog_n_o && !cfg_clk_o && !s_ready_o, "R1", "idle pins",
            {busy_o, cfg_prog_n_o, cfg_clk_o, s_ready_o}, 4'b0100);
        chk(result_o == 2'b00, "R1", "reset result", result_o, 0);
    endtask

    task automatic t_load(input int n, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2);
        logic [7:0] bytes [3];
        bit tail_ok;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        kick(n);
        chk(busy_o, "R9", "busy after start", busy_o, 1);
        handshake();
        for (int i = 0; i < n; i++) feed(bytes[i]);
        wait (cap_n >= 8 * n + 3);
        done_pin = 1'b1;
        wait_idle();
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            for (int k = 0; k < 8; k++) got[7-k] = capb[8*i+k];
            chk(got == bytes[i], "R4", "byte msb-first", got, bytes[i]);
        end
        tail_ok = 1'b1;
        for (int k = 8 * n; k < cap_n && k < 1024; k++) if (!capb[k]) tail_ok = 1'b0;
        chk(tail_ok, "R8", "flush data high", tail_ok, 1);
        chk(result_o == 2'b01, "R8", "ok result", result_o, 1);
        chk(!cfg_clk_o, "R8", "clock parked low", cfg_clk_o, 0);
        chk(min_lo >= HALF * TCK && min_hi >= HALF * TCK, "R5", "min phase x10",
            int'(10.0 * ((min_lo < min_hi) ? min_lo : min_hi)), int'(10.0 * HALF * TCK));
        done_pin = 1'b0;
    endtask

    task automatic t_tmo_prog();
        real t0;
        kick(1);
        t0 = $realtime;
        wait_idle();
        chk(result_o == 2'b10, "R2", "init never low", result_o, 2);
        chk(($realtime - t0) / TCK >= WAIT, "R2", "timeout length",
            int'(($realtime - t0) / TCK), WAIT);
        chk(cfg_prog_n_o, "R2", "program released", cfg_prog_n_o, 1);
    endtask

    task automatic t_tmo_wake();
        kick(1);
        wait (!cfg_prog_n_o);
        repeat (4) @(negedge clk);
        init_pin = 1'b0;
        wait (cfg_prog_n_o);
        chk(!busy_o == 1'b0, "R3", "program released, still busy", busy_o, 1);
        wait_idle();
        chk(result_o == 2'b10, "R3", "init never high", result_o, 2);
        chk(cap_n == 0, "R3", "no bits sent", cap_n, 0);
        init_pin = 1'b1;
    endtask

    task automatic t_tmo_done();
        kick(1);
        handshake();
        feed(8'h5A);
        wait_idle();
        chk(result_o == 2'b10, "R8", "done never high", result_o, 2);
        chk(cap_n > 8, "R8", "flush clocks issued", cap_n, 9);
    endtask

    task automatic t_crc();
        kick(3);
        handshake();
        feed(8'hC3);
        wait (cap_n == 8);
        init_pin = 1'b0;
        repeat (8) @(negedge clk);
        sdata = 8'hFF; svalid = 1'b1;
        wait_idle();
        svalid = 1'b0;
        chk(result_o == 2'b11, "R7", "checksum error", result_o, 3);
        chk(cap_n == 8, "R7", "no byte after error", cap_n, 8);
        init_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            svalid = i[0]; done_pin = i[1]; init_pin = i[2];
        end
        svalid = 1'b0; done_pin = 1'b0; init_pin = 1'b1;
        @(negedge clk);
        chk(result_o == 2'b01, "R9", "result held", result_o, 1);
        chk(!busy_o && !s_ready_o, "R6", "no ready when idle", s_ready_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load(3, 8'hA5, 8'h3C, 8'h81);
        t_load(2, 8'h00, 8'hFF, 8'h00);
        t_load(0, 8'h00, 8'h00, 8'h00);   // R6 zero count
        chk(cap_n >= 3, "R6", "zero count flushes only", cap_n, 3);
        t_hold();
        t_tmo_prog();
        t_tmo_wake();
        t_tmo_done();
        t_crc();
        t_load(1, 8'h69, 8'h00, 8'h00);
        chk(rdy_bad == 0, "R6", "ready outside fetch", rdy_bad, 0);
        report();
    end
endmodule